// File: doc/BRIEF.md
# Single-Bus Register Transfer Datapath

This block moves data between a bank of general registers and a small set of arithmetic latches over a single shared data bus. Only one source may place a value on the bus in any cycle. A three-operand add therefore cannot happen in one step. A small sequencer splits each command into a fixed series of bus transfers. Each transfer selects exactly one bus source and raises one or more load strobes, and each load captures the bus value at the clock edge.

The datapath has an operand latch Y, an adder, a sum latch Z, an incrementer and its own result latch W. Y is fed only from the bus and never drives it. The adder adds the bus to Y and writes only into Z; Z and W can each drive the bus. A controller issues a command with a one-cycle `start` strobe, a 2-bit command code and three register indices. It then watches `busy`, which stays high through the transfers, and `done`, which pulses once the last transfer has been written. A combinational debug port reads any register at any time.

Top module: `sbus_datapath`

## Requirements
- R1: A synchronous active-low reset clears every register, Y, Z and W to zero and drives `busy` and `done` low.
- R2: Command code 2'b01 (add) writes `R[idx_a] + R[idx_b]` (modulo 2^32) into `R[idx_dst]`. `busy` is high for exactly three cycles after the accepting edge: Y takes `R[idx_b]`, then Z takes `R[idx_a]` + Y, then Z is written to the destination.
- R3: In any cycle, at most one bus source is enabled: one register output, Z or W.
- R4: Command code 2'b00 (move) copies `R[idx_a]` into `R[idx_dst]`, with `busy` high for one cycle.
- R5: Command code 2'b10 (increment) writes `R[idx_a] + 1` (modulo 2^32) into `R[idx_dst]` through W, with `busy` high for two cycles. All-ones wraps to zero.
- R6: A `start` while `busy` is high is ignored. The running command completes unchanged and the second command's destination is not written.
- R7: Command code 2'b11 is reserved. A start carrying it raises neither `busy` nor `done` and changes no register.
- R8: When the destination index equals one or both source indices, the result is computed from the register values held before the command began.
- R9: `dbg_data` always shows the register selected by `dbg_idx`, without waiting for a clock edge.
- R10: A load strobe is raised only while some bus source is enabled, and Z loads only in the cycle right after Y loaded.
- R11: `done` is high for exactly one cycle, in the cycle after the final transfer, while `busy` is low. A new start is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command request, sampled when idle |
| cmd | input | 2 | Command code: 00 move, 01 add, 10 increment, 11 reserved |
| idx_dst | input | 5 | Destination register index |
| idx_a | input | 5 | First source register index |
| idx_b | input | 5 | Second source register index (add only) |
| dbg_idx | input | 5 | Debug read index |
| dbg_data | output | 32 | Contents of the register selected by dbg_idx |
| busy | output | 1 | High while a command's transfers are in progress |
| done | output | 1 | One-cycle pulse after the last transfer |

## Verification
The checker watches every cycle for several timing rules. It flags more than one enabled bus source and any load strobe raised while the bus is undriven. It checks that Z loads only directly after Y, that `done` lasts a single cycle and follows `busy`, and that the latched destination holds steady while `busy` is high. The arithmetic results can only be shown by the bench's scenarios: wraparound at all-ones, destination aliasing of its sources, rejection of a start while busy, the reserved code and per-command cycle counts. The bench compares these against a register model after every command.

// File: rtl/sbus_pkg.sv
// Package: shared types of the single-bus datapath.
// Assumes: command codes are fixed by the external controller and must not change.
package sbus_pkg;

    typedef enum logic [1:0] {
        CMD_MOVE = 2'b00,
        CMD_ADD  = 2'b01,
        CMD_INC  = 2'b10,
        CMD_RSVD = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADD_B,
        ST_ADD_A,
        ST_ADD_WB,
        ST_MOVE,
        ST_INC_A,
        ST_INC_WB
    } step_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_REG,
        SRC_Z,
        SRC_W
    } src_e;

endpackage

// File: rtl/sbus_regbank.sv
// Module: general register bank with per-register bus-out and bus-in controls.
// Assumes: reg_oe is one-hot or zero; a raised reg_ld bit captures bus_in at the edge.
module sbus_regbank #(
    parameter int NREG = 32,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] reg_oe,
    input  logic [NREG-1:0] reg_ld,
    input  logic [DW-1:0]   bus_in,
    input  logic [IW-1:0]   dbg_idx,
    output logic [DW-1:0]   rd_bus,
    output logic [DW-1:0]   dbg_data
);

    logic [DW-1:0] regs [NREG];

    // Register storage: clear on reset, capture the bus on a load strobe.
    always_ff @(posedge clk) begin
        for (int n = 0; n < NREG; n++) begin
            if (!rst_n)
                regs[n] <= '0;
            else if (reg_ld[n])
                regs[n] <= bus_in;
        end
    end

    // Bus contribution: AND-OR of the enabled register outputs.
    always_comb begin
        rd_bus = '0;
        for (int n = 0; n < NREG; n++)
            rd_bus = rd_bus | (regs[n] & {DW{reg_oe[n]}});
    end

    // Debug read: combinational view of one register.
    assign dbg_data = regs[dbg_idx];

endmodule

// File: rtl/sbus_oplatches.sv
// Module: operand latch Y, adder into Z, incrementer into W.
// Assumes: Y is never a bus source. The adder adds bus + Y, the incrementer adds bus + 1,
// and neither result reaches the bus except through its latch.
module sbus_oplatches #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] bus,
    input  logic          y_ld,
    input  logic          z_ld,
    input  logic          w_ld,
    output logic [DW-1:0] z_q,
    output logic [DW-1:0] w_q
);

    logic [DW-1:0] y_q;
    logic [DW-1:0] sum;
    logic [DW-1:0] incr;

    // Arithmetic paths: modulo-2^DW results.
    assign sum  = bus + y_q;
    assign incr = bus + DW'(1);

    // Y latch: holds the first add operand taken from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)
            y_q <= '0;
        else if (y_ld)
            y_q <= bus;
    end

    // Z latch: captures the adder output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            z_q <= '0;
        else if (z_ld)
            z_q <= sum;
    end

    // W latch: captures the incrementer output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            w_q <= '0;
        else if (w_ld)
            w_q <= incr;
    end

endmodule

// File: rtl/sbus_sequencer.sv
// Module: command sequencer that turns a command into timed bus transfers.
// Assumes: start is sampled only when idle. Each step enables at most one bus source.
// Indices are latched when a command is accepted.
module sbus_sequencer #(
    parameter int NREG = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      cmd,
    input  logic [IW-1:0]   idx_dst,
    input  logic [IW-1:0]   idx_a,
    input  logic [IW-1:0]   idx_b,
    output logic [NREG-1:0] reg_oe,
    output logic [NREG-1:0] reg_ld,
    output logic            z_oe,
    output logic            w_oe,
    output logic            y_ld,
    output logic            z_ld,
    output logic            w_ld,
    output logic            busy,
    output logic            done,
    output logic [IW-1:0]   lat_dst
);
    import sbus_pkg::*;

    step_e         step, step_nx;
    src_e          src;
    cmd_e          cmd_in;
    logic [IW-1:0] lat_a, lat_b, rd_idx;
    logic          wr_en, last_step, accept;

    assign cmd_in = cmd_e'(cmd);
    assign accept = (step == ST_IDLE) && start && (cmd_in != CMD_RSVD);

    // Next-step choice: fixed order per command, back to idle after the last transfer.
    always_comb begin
        step_nx = ST_IDLE;
        case (step)
            ST_IDLE: begin
                if (start) begin
                    case (cmd_in)
                        CMD_MOVE: step_nx = ST_MOVE;
                        CMD_ADD:  step_nx = ST_ADD_B;
                        CMD_INC:  step_nx = ST_INC_A;
                        default:  step_nx = ST_IDLE;
                    endcase
                end
            end
            ST_ADD_B: step_nx = ST_ADD_A;
            ST_ADD_A: step_nx = ST_ADD_WB;
            ST_INC_A: step_nx = ST_INC_WB;
            default:  step_nx = ST_IDLE;
        endcase
    end

    // Step register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step <= ST_IDLE;
        else
            step <= step_nx;
    end

    // Index latches: captured only when a command is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_dst <= '0;
            lat_a   <= '0;
            lat_b   <= '0;
        end else if (accept) begin
            lat_dst <= idx_dst;
            lat_a   <= idx_a;
            lat_b   <= idx_b;
        end
    end

    // Per-step controls: one bus source and its load strobes.
    always_comb begin
        src       = SRC_NONE;
        rd_idx    = lat_a;
        y_ld      = 1'b0;
        z_ld      = 1'b0;
        w_ld      = 1'b0;
        wr_en     = 1'b0;
        last_step = 1'b0;
        case (step)
            ST_ADD_B:  begin src = SRC_REG; rd_idx = lat_b; y_ld = 1'b1; end
            ST_ADD_A:  begin src = SRC_REG; rd_idx = lat_a; z_ld = 1'b1; end
            ST_ADD_WB: begin src = SRC_Z; wr_en = 1'b1; last_step = 1'b1; end
            ST_MOVE:   begin src = SRC_REG; rd_idx = lat_a; wr_en = 1'b1; last_step = 1'b1; end
            ST_INC_A:  begin src = SRC_REG; rd_idx = lat_a; w_ld = 1'b1; end
            ST_INC_WB: begin src = SRC_W; wr_en = 1'b1; last_step = 1'b1; end
            default:   src = SRC_NONE;
        endcase
    end

    // Per-register decode of read and write controls.
    for (genvar n = 0; n < NREG; n++) begin : g_dec
        assign reg_oe[n] = (src == SRC_REG) && (rd_idx == IW'(n));
        assign reg_ld[n] = wr_en && (lat_dst == IW'(n));
    end

    assign z_oe = (src == SRC_Z);
    assign w_oe = (src == SRC_W);
    assign busy = (step != ST_IDLE);

    // Completion pulse: one cycle after the final transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= last_step;
    end

endmodule

// File: rtl/sbus_datapath.sv
// Module: top of the single-bus datapath; joins the register bank, operator latches,
// sequencer and bus source multiplexer.
// Assumes: the bus is an AND-OR multiplexer and reads as zero when nothing drives it.
module sbus_datapath #(
    parameter int NREG = 32,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    cmd,
    input  logic [IW-1:0] idx_dst,
    input  logic [IW-1:0] idx_a,
    input  logic [IW-1:0] idx_b,
    input  logic [IW-1:0] dbg_idx,
    output logic [DW-1:0] dbg_data,
    output logic          busy,
    output logic          done
);

    logic [NREG-1:0] reg_oe, reg_ld;
    logic            z_oe, w_oe, y_ld, z_ld, w_ld;
    logic [DW-1:0]   rd_bus, z_q, w_q, bus;
    logic [IW-1:0]   lat_dst;

    // Bus source multiplexer: register bank, Z or W.
    assign bus = rd_bus | (z_q & {DW{z_oe}}) | (w_q & {DW{w_oe}});

    sbus_sequencer #(.NREG(NREG)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cmd     (cmd),
        .idx_dst (idx_dst),
        .idx_a   (idx_a),
        .idx_b   (idx_b),
        .reg_oe  (reg_oe),
        .reg_ld  (reg_ld),
        .z_oe    (z_oe),
        .w_oe    (w_oe),
        .y_ld    (y_ld),
        .z_ld    (z_ld),
        .w_ld    (w_ld),
        .busy    (busy),
        .done    (done),
        .lat_dst (lat_dst)
    );

    sbus_regbank #(.NREG(NREG), .DW(DW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_oe   (reg_oe),
        .reg_ld   (reg_ld),
        .bus_in   (bus),
        .dbg_idx  (dbg_idx),
        .rd_bus   (rd_bus),
        .dbg_data (dbg_data)
    );

    sbus_oplatches #(.DW(DW)) u_ops (
        .clk   (clk),
        .rst_n (rst_n),
        .bus   (bus),
        .y_ld  (y_ld),
        .z_ld  (z_ld),
        .w_ld  (w_ld),
        .z_q   (z_q),
        .w_q   (w_q)
    );

endmodule

// File: rtl/sbus_datapath_chk.sv
// Module: per-cycle protocol checker for the single-bus datapath, bound to the top.
// Assumes: the control signals it watches are visible by name in the top module.
module sbus_datapath_chk #(
    parameter int NREG = 32,
    localparam int IW  = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NREG-1:0] reg_oe,
    input logic [NREG-1:0] reg_ld,
    input logic            z_oe,
    input logic            w_oe,
    input logic            y_ld,
    input logic            z_ld,
    input logic            w_ld,
    input logic            busy,
    input logic            done,
    input logic [IW-1:0]   lat_dst
);

    assert_one_bus_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({reg_oe, z_oe, w_oe}) <= 1);

    assert_load_needs_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|reg_ld) || y_ld || z_ld || w_ld) |-> ((|reg_oe) || z_oe || w_oe));

    assert_z_after_y_R10: assert property (@(posedge clk) disable iff (!rst_n)
        z_ld |-> $past(y_ld));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_dst_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(lat_dst)));

endmodule

bind sbus_datapath sbus_datapath_chk #(.NREG(NREG)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_oe  (reg_oe),
    .reg_ld  (reg_ld),
    .z_oe    (z_oe),
    .w_oe    (w_oe),
    .y_ld    (y_ld),
    .z_ld    (z_ld),
    .w_ld    (w_ld),
    .busy    (busy),
    .done    (done),
    .lat_dst (lat_dst)
);

// File: tb/sbus_datapath_test.sv
// Bench: directed scenarios for the single-bus datapath, one task per scenario,
// compared against a register model.
module sbus_datapath_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cmd = 2'b00;
    logic [4:0]  idx_dst = '0, idx_a = '0, idx_b = '0, dbg_idx = '0;
    logic [31:0] dbg_data;
    logic        busy, done;

    int total = 0;
    int bad = 0;
    logic [31:0] model [32];

    sbus_datapath uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .idx_dst(idx_dst), .idx_a(idx_a), .idx_b(idx_b),
        .dbg_idx(dbg_idx), .dbg_data(dbg_data), .busy(busy), .done(done)
    );

    always #5 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compares every register through the debug port (R9) as one check.
    task automatic check_regs(string req);
        logic ok = 1'b1;
        total++;
        for (int r = 0; r < 32; r++) begin
            dbg_idx = 5'(r);
            #1;
            if (ok && dbg_data !== model[r]) begin
                ok = 1'b0;
                bad++;
                $display("FAIL %s reg %0d actual=%h expected=%h", req, r, dbg_data, model[r]);
            end
        end
    endtask

    task automatic apply_model(logic [1:0] c, int d, int a, int b);
        logic [31:0] va = model[a];
        logic [31:0] vb = model[b];
        case (c)
            2'b00: model[d] = va;
            2'b01: model[d] = va + vb;
            2'b10: model[d] = va + 32'd1;
            default: ;
        endcase
    endtask

    // Issues one command, measures busy length and the done pulse, updates the model.
    task automatic run_cmd(logic [1:0] c, int d, int a, int b, int exp_busy,
                           string req, bit full_check);
        int n = 0;
        @(negedge clk);
        start = 1'b1; cmd = c; idx_dst = 5'(d); idx_a = 5'(a); idx_b = 5'(b);
        @(negedge clk);
        start = 1'b0;
        while (busy === 1'b1 && n < 8) begin
            n++;
            @(negedge clk);
        end
        check({req, " busy cycles"}, 32'(n), 32'(exp_busy));
        check({req, " R11 done pulse"}, {31'd0, done}, {31'd0, exp_busy > 0});
        @(negedge clk);
        check({req, " R11 done drops"}, {31'd0, done}, 32'd0);
        apply_model(c, d, a, b);
        if (full_check) check_regs({req, " registers"});
    endtask

    task automatic t_reset(string req);
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < 32; r++) model[r] = '0;
        @(negedge clk);
        check({req, " busy low"}, {31'd0, busy}, 32'd0);
        check({req, " done low"}, {31'd0, done}, 32'd0);
        check_regs({req, " R9 all zero"});
    endtask

    task automatic t_basic();
        run_cmd(2'b10, 1, 0, 0, 2, "R5 inc r1<-r0", 1);
        run_cmd(2'b10, 2, 1, 0, 2, "R5 inc r2<-r1", 1);
        run_cmd(2'b00, 3, 2, 0, 1, "R4 move r3<-r2", 1);
        run_cmd(2'b01, 4, 2, 3, 3, "R2 add r4<-r2+r3", 1);
        run_cmd(2'b01, 31, 4, 1, 3, "R2 add r31<-r4+r1", 1);
        dbg_idx = 5'd31;
        #1;
        check("R9 debug read r31", dbg_data, 32'd5);
    endtask

    task automatic t_alias();
        run_cmd(2'b01, 4, 4, 4, 3, "R8 add r4<-r4+r4", 1);
        run_cmd(2'b01, 1, 2, 1, 3, "R8 add r1<-r2+r1", 1);
        run_cmd(2'b01, 2, 2, 31, 3, "R8 add r2<-r2+r31", 1);
        run_cmd(2'b10, 3, 3, 0, 2, "R8 inc r3<-r3", 1);
        run_cmd(2'b00, 5, 5, 0, 1, "R8 move r5<-r5", 1);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 32; i++) begin
            run_cmd(2'b01, 6, 6, 6, 3, "R2 doubling", 0);
            run_cmd(2'b10, 6, 6, 0, 2, "R5 plus one", 0);
        end
        dbg_idx = 5'd6;
        #1;
        check("R5 r6 all ones", dbg_data, 32'hFFFF_FFFF);
        run_cmd(2'b10, 7, 6, 0, 2, "R5 inc wraps to zero", 1);
        run_cmd(2'b01, 8, 6, 6, 3, "R2 add wraps", 1);
        dbg_idx = 5'd8;
        #1;
        check("R2 r8 wrap value", dbg_data, 32'hFFFF_FFFE);
    endtask

    task automatic t_busy_ignore();
        int n = 0;
        @(negedge clk);
        start = 1'b1; cmd = 2'b01; idx_dst = 5'd9; idx_a = 5'd6; idx_b = 5'd2;
        @(negedge clk);
        cmd = 2'b00; idx_dst = 5'd10; idx_a = 5'd6;
        while (busy === 1'b1 && n < 8) begin
            n++;
            if (n == 2) start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        check("R6 first command busy cycles", 32'(n), 32'd3);
        @(negedge clk);
        check("R6 no second sequence", {31'd0, busy}, 32'd0);
        apply_model(2'b01, 9, 6, 2);
        check_regs("R6 second command dropped");
    endtask

    task automatic t_reserved();
        run_cmd(2'b11, 11, 6, 6, 0, "R7 reserved code", 1);
    endtask

    // Random traffic; the checker's R3 and R10 properties run on every cycle of it.
    task automatic t_random();
        for (int i = 0; i < 200; i++) begin
            int c = $urandom_range(0, 2);
            int d = $urandom_range(0, 31);
            int a = ($urandom_range(0, 3) == 0) ? d : $urandom_range(0, 31);
            int b = ($urandom_range(0, 3) == 0) ? d : $urandom_range(0, 31);
            int nb = (c == 0) ? 1 : (c == 1) ? 3 : 2;
            run_cmd(2'(c), d, a, b, nb, "R2/R4/R5/R8 random op", (i % 20) == 19);
        end
        check_regs("R8 random final");
    endtask

    initial begin
        t_reset("R1 reset");
        t_basic();
        t_alias();
        t_wrap();
        t_busy_ignore();
        t_reserved();
        t_random();
        t_reset("R1 reset after traffic");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule